// File: doc/BRIEF.md
# Segment Base/Bounds Address Checker

This block sits between a processor's load/store path and memory. Every request carries a logical address and a two-bit segment class. The block checks the address against a limit and turns it into a physical address. A request that passes is forwarded downstream as a valid memory request. A request that fails raises a single-cycle exception instead, the downstream request is held back, and the faulting logical address is kept in a status register.

There are two modes. In relocation mode, each of four segments (code, heap, stack, data) has its own pair of registers. One holds a relocation offset. The other holds the segment size, and the request's class picks the pair to use. In fence mode, one fence value splits the address space. Addresses under the fence are refused, and the others go through unchanged. Software sets all registers through a small write-only configuration port.

The result is registered and appears one cycle after the request. The asynchronous active-low reset is released synchronously inside the block.

Top module: `seg_bb_guard`

## Requirements
- R1: After reset, `mem_valid` and `exc_pulse` are 0, `fault_addr` is 0, fence mode is off and every segment size is 0, so every request faults until the unit is configured.
- R2: In relocation mode, a request that passes gives `mem_valid`=1 one cycle later, with `mem_paddr` = logical address + offset of the selected segment, taken modulo 2^AW.
- R3: In relocation mode, a logical address greater than or equal to the selected segment's size faults. Size−1 passes and size faults.
- R4: The segment class is encoded as 2'b00 code, 2'b01 heap, 2'b10 stack and 2'b11 data. Each class uses only its own offset/size pair.
- R5: In fence mode, an address below the fence value faults. An address at or above it passes, with `mem_paddr` equal to the logical address and no relocation applied.
- R6: A faulting request gives `exc_pulse`=1 for exactly one cycle, one cycle after the request. In that cycle `mem_valid` is 0 and `mem_paddr` keeps its previous value.
- R7: `fault_addr` captures the logical address of each faulting request and holds it until the next fault.
- R8: A configuration write in cycle t applies to requests from cycle t+1 onward. A request in cycle t itself still sees the old value.
- R9: The configuration address map is as follows. Address 0 is the mode register, where bit 0 = 1 selects fence mode. Address 1 is the fence value. Address 4+s is the offset of segment s. Address 8+s is the size of segment s. Writes to addresses 2, 3 and 12–15 change nothing.
- R10: A cycle with no request gives `mem_valid`=0 and `exc_pulse`=0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | AW | Configuration write data |
| req_valid | input | 1 | Access request present |
| req_seg | input | 2 | Segment class of the request |
| req_addr | input | AW | Logical address |
| mem_valid | output | 1 | Checked memory request, one cycle after the access |
| mem_paddr | output | AW | Physical address of the last request that passed |
| exc_pulse | output | 1 | One-cycle protection exception |
| fault_addr | output | AW | Logical address of the most recent fault |

## Verification
Every result appears exactly one clock edge after the request edge: `mem_valid`, `mem_paddr`, `exc_pulse` and `fault_addr`. The bench drives a request on a falling edge and samples the outputs on the next falling edge, which lies halfway past the edge that registers them. Configuration writes take effect one edge after their strobe. To test R8, a write and a request share one cycle, and the request after it is then checked against the new value. Because reset release passes through a two-stage synchronizer, the bench waits several cycles after deasserting reset before the first check.

// File: rtl/seg_bb_pkg.sv
package seg_bb_pkg;
  localparam int SEG_W   = 2;
  localparam int NSEG    = 1 << SEG_W;
  localparam int CFG_AW  = SEG_W + 2;

  typedef enum logic [SEG_W-1:0] {
    SEG_CODE  = 2'b00,
    SEG_HEAP  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } seg_class_e;

  // configuration address groups (upper two bits of cfg_addr)
  localparam logic [1:0] GRP_CTRL  = 2'b00;
  localparam logic [1:0] GRP_BASE  = 2'b01;
  localparam logic [1:0] GRP_LIMIT = 2'b10;

  // sub-addresses inside the control group
  localparam logic [SEG_W-1:0] CTRL_MODE  = 2'd0;
  localparam logic [SEG_W-1:0] CTRL_FENCE = 2'd1;
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/seg_cfg_regs.sv
module seg_cfg_regs
  import seg_bb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [CFG_AW-1:0]        waddr,
  input  logic [AW-1:0]            wdata,
  output logic                     fence_en,
  output logic [AW-1:0]            fence_val,
  output logic [NSEG-1:0][AW-1:0]  base_val,
  output logic [NSEG-1:0][AW-1:0]  limit_val
);
  logic [1:0]       grp;
  logic [SEG_W-1:0] sub;

  assign grp = waddr[CFG_AW-1 -: 2];
  assign sub = waddr[SEG_W-1:0];

  // control registers
  logic          mode_en, fence_ld;
  logic          mode_q;
  logic [AW-1:0] fence_q;

  always_comb begin
    mode_en  = we && (grp == GRP_CTRL) && (sub == CTRL_MODE);
    fence_ld = we && (grp == GRP_CTRL) && (sub == CTRL_FENCE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      fence_q <= '0;
    end else begin
      if (mode_en)  mode_q  <= wdata[0];
      if (fence_ld) fence_q <= wdata;
    end
  end

  assign fence_en  = mode_q;
  assign fence_val = fence_q;

  // per-segment offset / size pairs
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic          base_ld, limit_ld;
    logic [AW-1:0] base_q, limit_q;

    always_comb begin
      base_ld  = we && (grp == GRP_BASE)  && (sub == SEG_W'(s));
      limit_ld = we && (grp == GRP_LIMIT) && (sub == SEG_W'(s));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q  <= '0;
        limit_q <= '0;
      end else begin
        if (base_ld)  base_q  <= wdata;
        if (limit_ld) limit_q <= wdata;
      end
    end

    assign base_val[s]  = base_q;
    assign limit_val[s] = limit_q;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_bb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]            laddr,
  input  logic [SEG_W-1:0]         seg,
  input  logic                     fence_en,
  input  logic [AW-1:0]            fence_val,
  input  logic [NSEG-1:0][AW-1:0]  base_val,
  input  logic [NSEG-1:0][AW-1:0]  limit_val,
  output logic [AW-1:0]            paddr,
  output logic                     fault,
  output logic [AW-1:0]            sel_limit
);
  logic [NSEG-1:0]          over;
  logic [NSEG-1:0][AW-1:0]  reloc;

  // every segment's comparator and adder run in parallel; class selects
  for (genvar s = 0; s < NSEG; s++) begin : g_chk
    assign over[s]  = (laddr >= limit_val[s]);
    assign reloc[s] = laddr + base_val[s];
  end

  logic below_fence;
  assign below_fence = (laddr < fence_val);

  always_comb begin
    sel_limit = limit_val[seg];
    if (fence_en) begin
      fault = below_fence;
      paddr = laddr;
    end else begin
      fault = over[seg];
      paddr = reloc[seg];
    end
  end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] laddr,
  input  logic [AW-1:0] paddr,
  input  logic          fault,
  output logic          mem_valid,
  output logic [AW-1:0] mem_paddr,
  output logic          exc_pulse,
  output logic [AW-1:0] fault_addr
);
  logic          valid_d, exc_d, pa_en, fa_en;
  logic          valid_q, exc_q;
  logic [AW-1:0] pa_q, fa_q;

  always_comb begin
    valid_d = req_valid && !fault;
    exc_d   = req_valid &&  fault;
    pa_en   = valid_d;
    fa_en   = exc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      exc_q   <= 1'b0;
      pa_q    <= '0;
      fa_q    <= '0;
    end else begin
      valid_q <= valid_d;
      exc_q   <= exc_d;
      if (pa_en) pa_q <= paddr;
      if (fa_en) fa_q <= laddr;
    end
  end

  assign mem_valid  = valid_q;
  assign exc_pulse  = exc_q;
  assign mem_paddr  = pa_q;
  assign fault_addr = fa_q;
endmodule

// File: rtl/seg_bb_guard.sv
module seg_bb_guard
  import seg_bb_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_seg,
  input  logic [AW-1:0]     req_addr,
  output logic              mem_valid,
  output logic [AW-1:0]     mem_paddr,
  output logic              exc_pulse,
  output logic [AW-1:0]     fault_addr
);
  logic                     rst_sync_n;
  logic                     fence_en;
  logic [AW-1:0]            fence_val;
  logic [NSEG-1:0][AW-1:0]  base_val;
  logic [NSEG-1:0][AW-1:0]  limit_val;
  logic [AW-1:0]            xl_paddr;
  logic                     xl_fault;
  logic [AW-1:0]            sel_limit;

  seg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  seg_cfg_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we        (cfg_we),
    .waddr     (cfg_addr),
    .wdata     (cfg_wdata),
    .fence_en  (fence_en),
    .fence_val (fence_val),
    .base_val  (base_val),
    .limit_val (limit_val)
  );

  seg_xlate #(.AW(AW)) u_xlate (
    .laddr     (req_addr),
    .seg       (req_seg),
    .fence_en  (fence_en),
    .fence_val (fence_val),
    .base_val  (base_val),
    .limit_val (limit_val),
    .paddr     (xl_paddr),
    .fault     (xl_fault),
    .sel_limit (sel_limit)
  );

  seg_out_stage #(.AW(AW)) u_out (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_valid  (req_valid),
    .laddr      (req_addr),
    .paddr      (xl_paddr),
    .fault      (xl_fault),
    .mem_valid  (mem_valid),
    .mem_paddr  (mem_paddr),
    .exc_pulse  (exc_pulse),
    .fault_addr (fault_addr)
  );
endmodule

// File: rtl/seg_bb_checker.sv
module seg_bb_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          mem_valid,
  input logic [AW-1:0] mem_paddr,
  input logic          exc_pulse,
  input logic [AW-1:0] fault_addr,
  input logic          fence_en,
  input logic [AW-1:0] fence_val,
  input logic [AW-1:0] sel_limit
);
  // R6: forwarding and exception never coincide
  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_valid && exc_pulse));

  // R10: idle cycle yields no output activity next cycle
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!mem_valid && !exc_pulse));

  // R7: fault address holds the logical address of the faulting request
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (exc_pulse -> (fault_addr == $past(req_addr))));

  // R7: fault address does not move without a fault
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_pulse |-> $stable(fault_addr));

  // R3: forwarded relocation-mode request was inside its segment
  assert_inside_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !fence_en) |=> (mem_valid -> ($past(req_addr) < $past(sel_limit))));

  // R5: fence mode forwards the raw address, refuses addresses below the fence
  assert_fence_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fence_en) |=>
      ((mem_valid -> (mem_paddr == $past(req_addr))) &&
       (exc_pulse -> ($past(req_addr) < $past(fence_val)))));

  // R6: paddr holds when nothing is forwarded
  assert_pa_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> $stable(mem_paddr));
endmodule

bind seg_bb_guard seg_bb_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .mem_valid  (mem_valid),
  .mem_paddr  (mem_paddr),
  .exc_pulse  (exc_pulse),
  .fault_addr (fault_addr),
  .fence_en   (fence_en),
  .fence_val  (fence_val),
  .sel_limit  (sel_limit)
);

// File: tb/seg_bb_guard_tb.sv
module seg_bb_guard_tb;
  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [3:0]    cfg_addr;
  logic [AW-1:0] cfg_wdata;
  logic          req_valid;
  logic [1:0]    req_seg;
  logic [AW-1:0] req_addr;
  logic          mem_valid;
  logic [AW-1:0] mem_paddr;
  logic          exc_pulse;
  logic [AW-1:0] fault_addr;

  seg_bb_guard #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_seg(req_seg),
    .req_addr(req_addr), .mem_valid(mem_valid), .mem_paddr(mem_paddr),
    .exc_pulse(exc_pulse), .fault_addr(fault_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench-side model of the configuration state
  logic [AW-1:0] m_base [4];
  logic [AW-1:0] m_lim  [4];
  logic          m_fen;
  logic [AW-1:0] m_fence;
  logic [AW-1:0] m_pa;
  logic [AW-1:0] m_fa;

  task automatic check(input bit ok, input string req,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_fault(input logic [AW-1:0] a, input logic [1:0] s);
    if (m_fen) return a < m_fence;
    return a >= m_lim[s];
  endfunction

  function automatic logic [AW-1:0] exp_pa(input logic [AW-1:0] a, input logic [1:0] s);
    if (m_fen) return a;
    return a + m_base[s];
  endfunction

  function automatic void model_write(input logic [3:0] ad, input logic [AW-1:0] d);
    case (ad[3:2])
      2'b00: begin
        if (ad[1:0] == 2'd0) m_fen = d[0];
        else if (ad[1:0] == 2'd1) m_fence = d;
      end
      2'b01: m_base[ad[1:0]] = d;
      2'b10: m_lim[ad[1:0]]  = d;
      default: ;
    endcase
  endfunction

  task automatic cfg_write(input logic [3:0] ad, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(ad, d);
  endtask

  // compare outputs against model for a request issued in the previous cycle
  task automatic expect_result(input logic [AW-1:0] a, input logic [1:0] s,
                               input bit f, input logic [AW-1:0] pa, input string req);
    if (f) begin
      m_fa = a;
      check(exc_pulse === 1'b1, {req, " exc"}, AW'(exc_pulse), 1);
      check(mem_valid === 1'b0, {req, " valid"}, AW'(mem_valid), 0);
      check(fault_addr === m_fa, {req, " fault_addr R7"}, fault_addr, m_fa);
      check(mem_paddr === m_pa, {req, " paddr hold R6"}, mem_paddr, m_pa);
    end else begin
      m_pa = pa;
      check(mem_valid === 1'b1, {req, " valid"}, AW'(mem_valid), 1);
      check(exc_pulse === 1'b0, {req, " exc"}, AW'(exc_pulse), 0);
      check(mem_paddr === m_pa, {req, " paddr"}, mem_paddr, m_pa);
      check(fault_addr === m_fa, {req, " fault_addr hold R7"}, fault_addr, m_fa);
    end
  endtask

  task automatic do_req(input logic [AW-1:0] a, input logic [1:0] s, input string req);
    bit f;
    logic [AW-1:0] pa;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_seg = s;
    f  = exp_fault(a, s);
    pa = exp_pa(a, s);
    @(negedge clk);
    req_valid = 1'b0;
    expect_result(a, s, f, pa, req);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EB0_0D17);
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    req_valid = 0; req_seg = 0; req_addr = 0;
    for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_lim[i] = '0; end
    m_fen = 0; m_fence = '0; m_pa = '0; m_fa = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(mem_valid === 1'b0, "R1 mem_valid", AW'(mem_valid), 0);
    check(exc_pulse === 1'b0, "R1 exc_pulse", AW'(exc_pulse), 0);
    check(fault_addr === '0, "R1 fault_addr", fault_addr, 0);
    for (int s = 0; s < 4; s++) do_req(AW'(s * 3), 2'(s), "R1 unconfigured");

    // R10: idle cycle produces nothing
    @(negedge clk);
    check(mem_valid === 1'b0 && exc_pulse === 1'b0, "R10 idle",
          AW'({mem_valid, exc_pulse}), 0);

    // R4/R9: configure distinct pairs per class (base 4+s, size 8+s)
    for (int s = 0; s < 4; s++) begin
      cfg_write(4'(4 + s), 32'h1000_0000 * (s + 1));
      cfg_write(4'(8 + s), 32'h100 << s);
    end
    for (int s = 0; s < 4; s++) do_req(32'h80, 2'(s), "R4 R2 class select");

    // R3: boundary size-1 passes, size faults
    for (int s = 0; s < 4; s++) begin
      do_req(m_lim[s] - 1, 2'(s), "R3 last inside");
      do_req(m_lim[s], 2'(s), "R3 at size");
    end

    // R2: modulo wrap of relocation
    cfg_write(4'd5, 32'hFFFF_FFF0);
    do_req(32'h20, 2'b01, "R2 wrap");

    // R9: unused addresses change nothing
    foreach (m_lim[i]) ;
    cfg_write(4'd2, 32'hFFFF_FFFF);
    cfg_write(4'd3, 32'hFFFF_FFFF);
    for (int ad = 12; ad < 16; ad++) cfg_write(4'(ad), 32'hFFFF_FFFF);
    for (int s = 0; s < 4; s++) begin
      do_req(m_lim[s] - 1, 2'(s), "R9 ignored write");
      do_req(m_lim[s], 2'(s), "R9 ignored write");
    end

    // R5: fence mode (mode reg at 0, bit 0; fence at 1)
    cfg_write(4'd1, 32'h0000_4000);
    cfg_write(4'd0, 32'h1);
    do_req(32'h0000_3FFF, 2'b10, "R5 below fence");
    do_req(32'h0000_4000, 2'b10, "R5 at fence");
    do_req(32'h0000_0000, 2'b00, "R5 zero");
    do_req(32'hFFFF_FFFF, 2'b11, "R5 top");

    // R6: fault pulse lasts one cycle
    do_req(32'h10, 2'b00, "R6 fault");
    @(negedge clk);
    check(exc_pulse === 1'b0, "R6 single cycle", AW'(exc_pulse), 0);

    // R8: write and request in the same cycle use the old value
    @(negedge clk);
    cfg_we = 1; cfg_addr = 4'd1; cfg_wdata = 32'h0000_0100;
    req_valid = 1; req_addr = 32'h0000_0200; req_seg = 2'b00;
    begin
      bit f0;
      f0 = exp_fault(32'h200, 2'b00);   // old fence 0x4000 -> fault
      @(negedge clk);
      cfg_we = 0; req_valid = 0;
      model_write(4'd1, 32'h100);
      expect_result(32'h200, 2'b00, f0, 32'h200, "R8 same cycle old value");
    end
    do_req(32'h0000_0200, 2'b00, "R8 next cycle new value");

    // back to relocation mode, randomized mix
    cfg_write(4'd0, 32'h0);
    for (int s = 0; s < 4; s++) begin
      cfg_write(4'(4 + s), $urandom);
      cfg_write(4'(8 + s), $urandom_range(32'h10000, 16));
    end
    for (int i = 0; i < 300; i++) begin
      logic [1:0] s;
      logic [AW-1:0] a;
      s = 2'($urandom_range(3, 0));
      case ($urandom_range(3, 0))
        0: a = m_lim[s] - 1;
        1: a = m_lim[s];
        2: a = $urandom_range(32'h1FFFF, 0);
        default: a = $urandom;
      endcase
      if ($urandom_range(7, 0) == 0) begin
        @(negedge clk);
        check(mem_valid === 1'b0 && exc_pulse === 1'b0, "R10 random idle",
              AW'({mem_valid, exc_pulse}), 0);
      end
      do_req(a, s, "R2 R3 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule